// File: doc/BRIEF.md
# External Data-Memory Stretch Timing Generator

This block sequences the bus control strobes for one external data-memory access made by a small processor core. A one-cycle start request carries a direction flag, a flag saying whether the upper address byte changed since the last access (a page miss), and a 3-bit stretch code. The block then drives the address latch enable, the read or write strobe, the address bus enable and the write-data output enable over a fixed schedule. When the last clock of the access has passed, it pulses a completion flag.

The system clock runs at the oscillator rate, with no clock division. One basic memory cycle lasts four clocks, and so does one stretch cycle. The stretch code does not map linearly to stretch cycles. The low four codes add 0 to 3 stretch cycles, and each of these widens the strobe by one full cycle and adds one clock of setup and one clock of hold. The high four codes add 7 to 10 stretch cycles. Of that extra time, two stretch cycles go to setup and one goes to hold. On a page miss the address latch pulse is also one stretch cycle wider.

Top module: `mem_stretch_timer`

## Requirements
- R1: With S stretch cycles (code 0..3 gives S = code; code 4..7 gives S = code + 3), an access occupies exactly 8 + 4·S clocks. The access is counted from index 0, the first clock after the start is taken.
- R2: Code 0 gives 3 setup clocks, a 2-clock strobe, then 3 hold clocks.
- R3: Codes 1, 2 and 3 give 4 setup clocks, a strobe of 4, 8 or 12 clocks, then 4 hold clocks.
- R4: Codes 4, 5, 6 and 7 give 12 setup clocks, a strobe of 16, 20, 24 or 28 clocks, then 8 hold clocks.
- R5: On a page miss, the address latch enable is high from index 0 for 2 clocks (codes 0..3) or 6 clocks (codes 4..7). On a page hit it stays low.
- R6: A read (write flag 0) pulses only the read strobe, and a write pulses only the write strobe. The two are never high together.
- R7: The address bus enable is high for every clock of the access. For writes only, the write-data output enable is high from index 1 through the last hold clock, so it covers the whole strobe.
- R8: The completion flag is high for exactly one clock, at index 8 + 4·S. All other outputs are low in that clock.
- R9: A start request during an access is ignored. The stretch code, direction and page flag are captured only when a start is taken and stay fixed until the access ends.
- R10: A start request in the same clock as the completion pulse is taken, and the next access begins at once in the following clock.
- R11: After synchronous active-low reset the block is idle, with all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oscillator rate) |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request to begin one access |
| write_i | input | 1 | 1 = write access, 0 = read access |
| page_miss_i | input | 1 | 1 = upper address changed, latch pulse needed |
| stretch_i | input | 3 | Stretch code, captured with the start |
| ale_o | output | 1 | Address latch enable |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| addr_oe_o | output | 1 | Address bus drive enable |
| data_oe_o | output | 1 | Write-data bus drive enable |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The completion pulse of one access and the acceptance of the next start can land in the same clock. The bench provokes this by raising the start request in exactly the clock where it expects the completion pulse. It then checks that the new access's index 0 follows in the very next clock, with its latch and enable pattern intact. A second overlap, a start raised while an access is under way with a different code, is judged by comparing every later clock against the waveform of the original code.

// File: rtl/stretch_pkg.sv
// Package: shared widths and the per-access timing profile type.
// Assumes every phase length fits in PH_W bits (longest access 48 clocks).
package stretch_pkg;

    localparam int PH_W   = 8;
    localparam int CODE_W = 3;

    // Timing profile of one access, as clock indices from the first access clock.
    typedef struct packed {
        logic [PH_W-1:0] ale_end;     // first index with latch enable low
        logic [PH_W-1:0] strobe_beg;  // first strobe index
        logic [PH_W-1:0] strobe_end;  // first index after the strobe
        logic [PH_W-1:0] last_idx;    // last index of the access
    } profile_t;

endpackage

// File: rtl/stretch_decode.sv
// Module: stretch_decode
// Turns a stretch code and a page-miss flag into a timing profile.
// Assumes: CYC_CLKS is even and at least 2. Purely combinational.
module stretch_decode
    import stretch_pkg::*;
#(
    parameter int CYC_CLKS = 4,
    parameter int ALE_CLKS = 2
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              miss_i,
    output profile_t          prof_o
);

    localparam logic [PH_W-1:0] CYC   = PH_W'(CYC_CLKS);
    localparam logic [PH_W-1:0] ALE_B = PH_W'(ALE_CLKS);

    logic [PH_W-1:0] n_stretch;
    logic [PH_W-1:0] setup_len;
    logic [PH_W-1:0] strobe_len;
    logic [PH_W-1:0] hold_len;

    // Map the code to its non-linear stretch count.
    always_comb begin
        if (code_i[CODE_W-1]) n_stretch = PH_W'(code_i) + PH_W'(3);
        else                  n_stretch = PH_W'(code_i);
    end

    // Split the access into setup, strobe and hold by stretch range.
    always_comb begin
        if (code_i == '0) begin
            setup_len  = CYC - PH_W'(1);
            strobe_len = CYC >> 1;
            hold_len   = CYC - PH_W'(1);
        end else if (!code_i[CODE_W-1]) begin
            setup_len  = CYC;
            strobe_len = PH_W'(CYC * n_stretch);
            hold_len   = CYC;
        end else begin
            setup_len  = PH_W'(CYC * PH_W'(3));
            strobe_len = PH_W'(CYC * (n_stretch - PH_W'(3)));
            hold_len   = PH_W'(CYC * PH_W'(2));
        end
    end

    // Assemble the index boundaries used by the strobe generator.
    always_comb begin
        if (!miss_i)                 prof_o.ale_end = '0;
        else if (code_i[CODE_W-1])   prof_o.ale_end = ALE_B + CYC;
        else                         prof_o.ale_end = ALE_B;
        prof_o.strobe_beg = setup_len;
        prof_o.strobe_end = setup_len + strobe_len;
        prof_o.last_idx   = setup_len + strobe_len + hold_len - PH_W'(1);
    end

endmodule

// File: rtl/stretch_seq.sv
// Module: stretch_seq
// Access sequencer: takes a start while idle, captures the profile and
// attributes, counts clock indices and emits the one-clock done pulse.
// Assumes: start while busy is dropped; synchronous active-low reset.
module stretch_seq
    import stretch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_i,
    input  logic              miss_i,
    input  logic [CODE_W-1:0] code_i,
    input  profile_t          prof_i,
    output logic              busy_o,
    output logic [PH_W-1:0]   cnt_o,
    output profile_t          prof_o,
    output logic              write_o,
    output logic              miss_o,
    output logic [CODE_W-1:0] code_o,
    output logic              last_o,
    output logic              done_o
);

    logic take;

    assign take   = start_i && !busy_o;
    assign last_o = busy_o && (cnt_o == prof_o.last_idx);

    // Busy flag and clock-index counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_o  <= '0;
        end else if (take) begin
            busy_o <= 1'b1;
            cnt_o  <= '0;
        end else if (last_o) begin
            busy_o <= 1'b0;
            cnt_o  <= '0;
        end else if (busy_o) begin
            cnt_o  <= cnt_o + PH_W'(1);
        end
    end

    // Capture access attributes only when a start is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prof_o  <= '0;
            write_o <= 1'b0;
            miss_o  <= 1'b0;
            code_o  <= '0;
        end else if (take) begin
            prof_o  <= prof_i;
            write_o <= write_i;
            miss_o  <= miss_i;
            code_o  <= code_i;
        end
    end

    // One-clock completion pulse after the last hold clock.
    always_ff @(posedge clk) begin
        if (!rst_n) done_o <= 1'b0;
        else        done_o <= last_o;
    end

endmodule

// File: rtl/strobe_gen.sv
// Module: strobe_gen
// Derives the bus control outputs from the running index and profile.
// Assumes: cnt_i is valid only while busy_i is high. Combinational.
module strobe_gen
    import stretch_pkg::*;
(
    input  logic            busy_i,
    input  logic [PH_W-1:0] cnt_i,
    input  profile_t        prof_i,
    input  logic            write_i,
    output logic            ale_o,
    output logic            rd_o,
    output logic            wr_o,
    output logic            addr_oe_o,
    output logic            data_oe_o
);

    logic in_strobe;

    // Decode each control window from the clock index.
    always_comb begin
        in_strobe = busy_i && (cnt_i >= prof_i.strobe_beg) && (cnt_i < prof_i.strobe_end);
        ale_o     = busy_i && (cnt_i < prof_i.ale_end);
        rd_o      = in_strobe && !write_i;
        wr_o      = in_strobe && write_i;
        addr_oe_o = busy_i;
        data_oe_o = busy_i && write_i && (cnt_i != '0);
    end

endmodule

// File: rtl/mem_stretch_timer.sv
// Module: mem_stretch_timer (top)
// Control-strobe timer for one stretched external data-memory access.
// Assumes: system clock equals the oscillator clock; one memory or
// stretch cycle is CYC_CLKS clocks; synchronous active-low reset.
module mem_stretch_timer
    import stretch_pkg::*;
#(
    parameter int CYC_CLKS = 4,
    parameter int ALE_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              write_i,
    input  logic              page_miss_i,
    input  logic [CODE_W-1:0] stretch_i,
    output logic              ale_o,
    output logic              rd_o,
    output logic              wr_o,
    output logic              addr_oe_o,
    output logic              data_oe_o,
    output logic              done_o
);

    profile_t          prof_next;
    profile_t          prof_q;
    logic              busy;
    logic [PH_W-1:0]   cnt;
    logic              write_q;
    logic              miss_q;
    logic [CODE_W-1:0] code_q;
    logic              last_hit;

    stretch_decode #(
        .CYC_CLKS (CYC_CLKS),
        .ALE_CLKS (ALE_CLKS)
    ) u_decode (
        .code_i (stretch_i),
        .miss_i (page_miss_i),
        .prof_o (prof_next)
    );

    stretch_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .write_i (write_i),
        .miss_i  (page_miss_i),
        .code_i  (stretch_i),
        .prof_i  (prof_next),
        .busy_o  (busy),
        .cnt_o   (cnt),
        .prof_o  (prof_q),
        .write_o (write_q),
        .miss_o  (miss_q),
        .code_o  (code_q),
        .last_o  (last_hit),
        .done_o  (done_o)
    );

    strobe_gen u_strobe (
        .busy_i    (busy),
        .cnt_i     (cnt),
        .prof_i    (prof_q),
        .write_i   (write_q),
        .ale_o     (ale_o),
        .rd_o      (rd_o),
        .wr_o      (wr_o),
        .addr_oe_o (addr_oe_o),
        .data_oe_o (data_oe_o)
    );

endmodule

// File: rtl/stretch_timer_chk.sv
// Module: stretch_timer_chk
// Property checker bound into mem_stretch_timer.
// Assumes: observes top ports plus sequencer state; drives nothing.
module stretch_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       ale_o,
    input logic       rd_o,
    input logic       wr_o,
    input logic       addr_oe_o,
    input logic       data_oe_o,
    input logic       done_o,
    input logic       busy,
    input logic       last_hit,
    input logic       miss_q,
    input logic [2:0] code_q
);

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_o && wr_o));

    assert_wr_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> data_oe_o);

    assert_strobe_in_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o || wr_o) |-> addr_oe_o);

    assert_ale_only_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ale_o |-> miss_q);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_after_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy) && !addr_oe_o));

    assert_code_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_hit) |=> (busy && $stable(code_q)));

    assert_chain_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> busy);

endmodule

bind mem_stretch_timer stretch_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ale_o     (ale_o),
    .rd_o      (rd_o),
    .wr_o      (wr_o),
    .addr_oe_o (addr_oe_o),
    .data_oe_o (data_oe_o),
    .done_o    (done_o),
    .busy      (busy),
    .last_hit  (last_hit),
    .miss_q    (miss_q),
    .code_q    (code_q)
);

// File: tb/mem_stretch_timer_tb.sv
// Bench: directed corners plus seeded random accesses, each clock of each
// access compared with a waveform computed from the requirements.
module mem_stretch_timer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       write_i = 1'b0;
    logic       page_miss_i = 1'b0;
    logic [2:0] stretch_i = 3'd0;
    logic       ale_o, rd_o, wr_o, addr_oe_o, data_oe_o, done_o;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    mem_stretch_timer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .write_i     (write_i),
        .page_miss_i (page_miss_i),
        .stretch_i   (stretch_i),
        .ale_o       (ale_o),
        .rd_o        (rd_o),
        .wr_o        (wr_o),
        .addr_oe_o   (addr_oe_o),
        .data_oe_o   (data_oe_o),
        .done_o      (done_o)
    );

    // Requirement-level timing numbers.
    function automatic int f_stretch(input int code);
        return (code < 4) ? code : code + 3;
    endfunction
    function automatic int f_total(input int code);
        return 8 + 4 * f_stretch(code);
    endfunction
    function automatic int f_strobe(input int code);
        int w[8] = '{2, 4, 8, 12, 16, 20, 24, 28};
        return w[code];
    endfunction
    function automatic int f_setup(input int code);
        if (code == 0) return 3;
        if (code < 4)  return 4;
        return 12;
    endfunction
    function automatic int f_ale(input int code, input bit miss);
        if (!miss) return 0;
        return (code < 4) ? 2 : 6;
    endfunction
    // Expected {ale, rd, wr, addr_oe, data_oe, done} at index i.
    function automatic logic [5:0] f_expect(input int code, input bit miss, input bit w, input int i);
        int  t  = f_total(code);
        int  su = f_setup(code);
        bit  sb = (i >= su) && (i < su + f_strobe(code));
        return {i < f_ale(code, miss), sb && !w, sb && w, i < t,
                w && (i >= 1) && (i < t), i == t};
    endfunction
    function automatic string f_req(input int code, input logic [5:0] diff);
        if (diff[5]) return "R5";
        if (diff[4] || diff[3]) return (code == 0) ? "R2" : (code < 4) ? "R3" : "R4";
        if (diff[2] || diff[1]) return "R7";
        return "R8";
    endfunction

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp_v);
        n_run++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: outputs act=%b exp=%b at %0t", req, act, exp_v, $time);
        end
    endtask

    // Runs one access starting at the current negedge; returns at the negedge
    // that sampled the done clock. inject=1 raises a foreign start at index 5.
    task automatic do_access(input int code, input bit miss, input bit w, input bit inject);
        int t = f_total(code);
        start_i = 1'b1; stretch_i = 3'(code); page_miss_i = miss; write_i = w;
        for (int i = 0; i <= t; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (inject && i == 5) begin
                start_i = 1'b1; stretch_i = 3'(7 - code);
                page_miss_i = !miss; write_i = !w;
            end
            if (inject && i == 5)
                check("R9", {ale_o, rd_o, wr_o, addr_oe_o, data_oe_o, done_o},
                      f_expect(code, miss, w, i));
            else begin
                logic [5:0] a, e;
                a = {ale_o, rd_o, wr_o, addr_oe_o, data_oe_o, done_o};
                e = f_expect(code, miss, w, i);
                check(inject ? "R9" : f_req(code, a ^ e), a, e);
            end
        end
        start_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check("R8", {ale_o, rd_o, wr_o, addr_oe_o, data_oe_o, done_o}, 6'b0);
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: act=hung exp=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", {ale_o, rd_o, wr_o, addr_oe_o, data_oe_o, done_o}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", {ale_o, rd_o, wr_o, addr_oe_o, data_oe_o, done_o}, 6'b0);

        // R1 R2 R3 R4 R5 R6: every code, read miss and write hit
        for (int c = 0; c < 8; c++) begin
            do_access(c, 1'b1, 1'b0, 1'b0); idle(1);
            do_access(c, 1'b0, 1'b1, 1'b0); idle(1);
        end
        // R9: start during access ignored, long and short codes
        do_access(6, 1'b1, 1'b1, 1'b1); idle(2);
        do_access(1, 1'b0, 1'b0, 1'b1); idle(2);
        // R10: start in the done clock, chained accesses without gap
        do_access(0, 1'b1, 1'b1, 1'b0);
        do_access(4, 1'b1, 1'b0, 1'b0);
        do_access(7, 1'b0, 1'b1, 1'b0);
        idle(2);

        // Random mix, sometimes chained (R10), sometimes gapped
        for (int k = 0; k < 60; k++) begin
            int c = int'($urandom_range(0, 7));
            do_access(c, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      ($urandom_range(0, 5) == 0));
            if ($urandom_range(0, 2) != 0) idle(int'($urandom_range(1, 3)));
        end
        idle(2);

        // R11: reset in mid-access returns to idle
        start_i = 1'b1; stretch_i = 3'd5; page_miss_i = 1'b1; write_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", {ale_o, rd_o, wr_o, addr_oe_o, data_oe_o, done_o}, 6'b0);
        rst_n = 1'b1;
        idle(2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule